// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fixed reference clock into a one-cycle enable pulse at sixteen times the serial bit rate, for use by the sampling and shifting logic of an asynchronous serial port. The rate is set by a divisor in 16.6 fixed point. A 16-bit whole part sets the base period in reference cycles. A 6-bit fraction is spread over the ticks: an accumulator adds the fraction at every tick, and one extra reference cycle is inserted whenever the accumulator wraps past 64. Over any 64 ticks the average period is then exactly (64*I + F)/64 cycles, so the bit rate is 4*fclk/(64*I + F).

Software writes the whole part and the fraction into two holding registers. Neither one reaches the generator until a write to the line-control strobe copies both holding values into the working divisor. The generator then restarts its count from the new value. A line-control write that carries no new divisor still performs this copy. Ticks are produced only while the port-enable input is high and the working divisor is legal. The working divisor can be read back at all times.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset the working divisor reads back as whole part 0 and fraction 0, and no tick is produced, even with uartEn high.
- R2: wrInt stores wrData[15:0] and wrFrac stores wrData[5:0] in holding registers. wrData[15:6] is ignored on a fraction write. Neither write changes the readback or the tick spacing until a line-control write.
- R3: A wrLineCtl pulse copies both holding values into the working divisor, readable in the next cycle, whatever wrData holds. If a holding register is written in the same cycle as wrLineCtl, the copy takes the value held before that cycle.
- R4: After a commit with uartEn high and a legal divisor, the first tick is high I+1 cycles after the clock edge that sampled wrLineCtl. Here I is the new whole part.
- R5: With fraction 0, ticks repeat exactly every I cycles. Each tick is one cycle wide, and with I = 1 the tick stays high every cycle.
- R6: With fraction F, every gap between successive ticks is I or I+1 cycles, and any 64 consecutive gaps starting after a commit add up to exactly 64*I + F cycles.
- R7: No tick is produced while uartEn is low. When uartEn rises, the first tick is high I cycles after the edge that samples it high.
- R8: A whole part of 0, or a whole part of 65535 with a non-zero fraction, is illegal and produces no ticks. 65535 with fraction 0 is legal.
- R9: activeInt and activeFrac always show the working divisor, whether uartEn is high or low and whether the divisor is legal or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| uartEn | input | 1 | Port enable; ticks are produced only while it is high |
| wrInt | input | 1 | Write strobe for the whole-part holding register |
| wrFrac | input | 1 | Write strobe for the fraction holding register |
| wrLineCtl | input | 1 | Line-control write strobe; commits the holding values |
| wrData | input | 16 | Write data for both holding registers |
| tick16 | output | 1 | One-cycle enable at sixteen times the bit rate |
| activeInt | output | 16 | Working whole part |
| activeFrac | output | 6 | Working fraction |

## Verification
The divisor is tried with:
- a whole part of 1, to show a tick that stays high every cycle;
- small whole parts with fraction 0, to show exact fixed spacing;
- fractions of 1, 5, 32 and 63, to expose an accumulator that never wraps, wraps too often or drops the last carry.

The 64-gap span tells an exact fractional average apart from a truncated one. The gap bounds catch an inserted cycle that lands in the wrong place. Separate patterns cover:
- holding writes without a commit, a bare commit, and a holding write in the same cycle as a commit, which separate shadowed from direct update;
- zero, the top whole part with and without a fraction, and a low enable, which check that ticks are suppressed.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

  // Strobes from the control half to the counting datapath.
  typedef struct packed {
    logic restart;   // reload the period counter and clear the accumulator
    logic advance;   // a tick is issued: accumulate the fraction and reload
  } ctlStrobe_t;

endpackage

// File: rtl/bgen_div_regs.sv
module bgen_div_regs #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrInt,
  input  logic              wrFrac,
  input  logic              wrLineCtl,
  input  logic [INT_W-1:0]  wrData,
  output logic [INT_W-1:0]  activeInt,
  output logic [FRAC_W-1:0] activeFrac
);

  logic [INT_W-1:0]  shadowInt;
  logic [FRAC_W-1:0] shadowFrac;

  // Holding registers: written by software, invisible to the generator.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowInt  <= '0;
      shadowFrac <= '0;
    end else begin
      if (wrInt)  shadowInt  <= wrData;
      if (wrFrac) shadowFrac <= wrData[FRAC_W-1:0];
    end
  end

  // Working divisor: only a line-control write copies the holding values.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeInt  <= '0;
      activeFrac <= '0;
    end else if (wrLineCtl) begin
      activeInt  <= shadowInt;
      activeFrac <= shadowFrac;
    end
  end

  // R2: without a line-control write the working divisor does not move
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrLineCtl |=> ($stable(activeInt) && $stable(activeFrac)));

  // R3: a commit takes the holding values present before the commit edge
  p_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrLineCtl |=> (activeInt == $past(shadowInt) && activeFrac == $past(shadowFrac)));

endmodule

// File: rtl/bgen_ctrl.sv
module bgen_ctrl
  import bgen_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              uartEn,
  input  logic              wrLineCtl,
  input  logic [INT_W-1:0]  activeInt,
  input  logic [FRAC_W-1:0] activeFrac,
  input  logic              cntZero,
  output ctlStrobe_t        strobe,
  output logic              tick
);

  localparam logic [INT_W-1:0] INT_MAX = {INT_W{1'b1}};

  logic divLegal;
  logic runQ;
  logic commitD;

  // Zero is never legal; the top whole part leaves no room for a fraction.
  assign divLegal = (activeInt != '0) &&
                    !((activeInt == INT_MAX) && (activeFrac != '0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      commitD <= 1'b0;
    end else begin
      runQ    <= uartEn && divLegal;
      commitD <= wrLineCtl;
    end
  end

  always_comb begin
    strobe.restart = !runQ || commitD;
    tick           = runQ && !commitD && cntZero;
    strobe.advance = tick;
  end

  // R7: enable low on one edge means no tick in the following cycle
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !uartEn |=> !tick);

  // R8: a zero whole part never yields a tick
  p_invalid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (activeInt == '0) |-> !tick);

  // R5: with a period above one, a tick never lasts two cycles
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && activeInt > 1 && !wrLineCtl) |=> !tick);

endmodule

// File: rtl/bgen_dp.sv
module bgen_dp
  import bgen_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [INT_W-1:0]  activeInt,
  input  logic [FRAC_W-1:0] activeFrac,
  output logic              cntZero
);

  localparam logic [INT_W-1:0] ONE = {{(INT_W-1){1'b0}}, 1'b1};

  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   accSum;
  logic [INT_W-1:0]  basePeriod;

  assign accSum     = {1'b0, acc} + {1'b0, activeFrac};
  assign basePeriod = activeInt - ONE;
  assign cntZero    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      acc <= '0;
    end else if (strobe.restart) begin
      cnt <= basePeriod;
      acc <= '0;
    end else if (strobe.advance) begin
      acc <= accSum[FRAC_W-1:0];
      // A carry out of the fraction stretches this period by one cycle.
      cnt <= accSum[FRAC_W] ? activeInt : basePeriod;
    end else if (!cntZero) begin
      cnt <= cnt - ONE;
    end
  end

  // R6: after a tick the counter is reloaded to a period of I or I+1
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.restart) |=>
      (cnt == $past(activeInt) || cnt == $past(basePeriod)));

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import bgen_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              uartEn,
  input  logic              wrInt,
  input  logic              wrFrac,
  input  logic              wrLineCtl,
  input  logic [INT_W-1:0]  wrData,
  output logic              tick16,
  output logic [INT_W-1:0]  activeInt,
  output logic [FRAC_W-1:0] activeFrac
);

  ctlStrobe_t strobe;
  logic       cntZero;

  bgen_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrInt(wrInt), .wrFrac(wrFrac),
    .wrLineCtl(wrLineCtl), .wrData(wrData),
    .activeInt(activeInt), .activeFrac(activeFrac)
  );

  bgen_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .wrLineCtl(wrLineCtl),
    .activeInt(activeInt), .activeFrac(activeFrac), .cntZero(cntZero),
    .strobe(strobe), .tick(tick16)
  );

  bgen_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .activeInt(activeInt), .activeFrac(activeFrac), .cntZero(cntZero)
  );

endmodule

// File: tb/sim_baud_frac_gen.sv
module sim_baud_frac_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        uartEn = 1'b0;
  logic        wrInt = 1'b0, wrFrac = 1'b0, wrLineCtl = 1'b0;
  logic [15:0] wrData = '0;
  logic        tick16;
  logic [15:0] activeInt;
  logic [5:0]  activeFrac;

  int checks = 0;
  int errors = 0;

  baud_frac_gen u0 (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .wrInt(wrInt), .wrFrac(wrFrac),
    .wrLineCtl(wrLineCtl), .wrData(wrData), .tick16(tick16),
    .activeInt(activeInt), .activeFrac(activeFrac)
  );

  always #4 clk = ~clk;

  // Stimulus table: whole part, fraction, expected span of 64 gaps (64*I+F).
  localparam int NV = 6;
  localparam int VI   [NV] = '{1, 2, 3, 4, 7, 2};
  localparam int VF   [NV] = '{0, 0, 5, 63, 32, 1};
  localparam int VSPAN[NV] = '{64, 128, 197, 319, 480, 129};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int which, input logic [15:0] d);
    @(negedge clk);
    wrData = d;
    if (which == 0) wrInt = 1'b1;
    if (which == 1) wrFrac = 1'b1;
    if (which == 2) wrLineCtl = 1'b1;
    @(negedge clk);
    wrInt = 1'b0; wrFrac = 1'b0; wrLineCtl = 1'b0;
  endtask

  task automatic setDiv(input int i, input int f);
    pulse(0, 16'(i));
    pulse(1, 16'(f));
    pulse(2, 16'hA5A5);
  endtask

  function automatic int countTicks(input int cycles);
    return 0;
  endfunction

  task automatic tickCount(input int cycles, output int cnt);
    cnt = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (tick16) cnt++;
    end
  endtask

  // Called right after the restarting action; counts negedges from there.
  task automatic measure(input int i, input int f, input int span, input bit full,
                         input string tag);
    int n = 0, ticks = 0, firstN = 0, prevN = 0, lastN = 0, bad = 0;
    int need = full ? 65 : 1;
    while (ticks < need && n < 70000) begin
      @(negedge clk);
      n++;
      if (tick16) begin
        ticks++;
        if (ticks == 1) firstN = n;
        else if (f == 0 ? (n - prevN != i) : (n - prevN < i || n - prevN > i + 1)) bad++;
        prevN = n;
        if (ticks == 65) lastN = n;
      end
    end
    chk(firstN == i, {tag, " R4 first tick"}, firstN, i);
    if (full) begin
      chk(bad == 0, (f == 0) ? "R5 gap spacing" : "R6 gap bounds", bad, 0);
      chk(lastN - firstN == span, (f == 0) ? "R5 64-gap span" : "R6 64-gap span",
          lastN - firstN, span);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tick16 == 1'b0, "R1 tick in reset", tick16, 0);
    chk(activeInt == 0 && activeFrac == 0, "R1 divisor in reset", activeInt, 0);
    rstN = 1'b1;
    uartEn = 1'b1;
    tickCount(50, c);
    chk(c == 0, "R1 no ticks after reset", c, 0);

    // R2: holding writes alone do not reach the working divisor
    pulse(0, 16'd5);
    pulse(1, 16'hFFC5);
    tickCount(20, c);
    chk(activeInt == 0 && activeFrac == 0, "R2 readback before commit", activeInt, 0);
    chk(c == 0, "R2 no ticks before commit", c, 0);
    pulse(2, 16'h0000);
    chk(activeInt == 5, "R3 commit whole part", activeInt, 5);
    chk(activeFrac == 5, "R2 fraction uses low 6 bits", activeFrac, 5);

    // Table walk: R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      setDiv(VI[v], VF[v]);
      chk(activeInt == 16'(VI[v]) && activeFrac == 6'(VF[v]), "R9 readback",
          activeInt, VI[v]);
      measure(VI[v], VF[v], VSPAN[v], 1'b1, "table");
    end

    // R2/R3: a held write keeps the old rate until a bare commit
    setDiv(3, 0);
    measure(3, 0, 192, 1'b1, "period3");
    pulse(0, 16'd9);
    tickCount(30, c);
    chk(c == 10, "R2 rate unchanged by holding write", c, 10);
    pulse(2, 16'hFFFF);
    measure(9, 0, 576, 1'b1, "bare commit R3");

    // R7: enable low stops ticks, readback kept (R9)
    @(negedge clk); uartEn = 1'b0;
    tickCount(100, c);
    chk(c == 0, "R7 no ticks with enable low", c, 0);
    chk(activeInt == 9, "R9 readback while disabled", activeInt, 9);
    @(negedge clk); uartEn = 1'b1;
    begin
      int n = 0;
      while (!tick16 && n < 100) begin @(negedge clk); n++; end
      chk(n == 9, "R7 first tick after enable", n, 9);
    end

    // R8: illegal divisors
    setDiv(0, 0);
    tickCount(100, c);
    chk(c == 0, "R8 zero whole part", c, 0);
    setDiv(65535, 3);
    tickCount(200, c);
    chk(c == 0, "R8 top whole part with fraction", c, 0);
    chk(activeInt == 65535 && activeFrac == 3, "R9 readback of illegal divisor",
        activeFrac, 3);
    setDiv(65535, 0);
    measure(65535, 0, 0, 1'b0, "R8 top whole part legal");

    // R3: holding write in the same cycle as a commit is not taken
    @(negedge clk); wrData = 16'd4; wrInt = 1'b1; wrLineCtl = 1'b1;
    @(negedge clk); wrInt = 1'b0; wrLineCtl = 1'b0;
    chk(activeInt == 65535, "R3 same-cycle write not committed", activeInt, 65535);
    pulse(2, 16'h0);
    chk(activeInt == 4 && activeFrac == 0, "R3 later commit", activeInt, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule